// File: doc/BRIEF.md
# Calendar Set/Read Sequencer for a Serial Clock Chip

This block sits between a host and a byte-level serial master that talks to a battery-backed clock chip. The clock chip keeps its calendar as packed BCD bytes. The host works in plain binary fields. The sequencer converts between the two representations. For each host command it issues a fixed list of single-byte read or write transactions on a request/acknowledge port.

There are three commands. A set command takes binary seconds, minutes, hours, weekday, day of month, a 0-based month and a year counted from 1900. It then removes the chip's write protection, freezes the oscillator, loads the seven calendar registers, restarts the oscillator and restores write protection. A read command fetches the seven calendar registers and presents binary fields. A probe command writes a marker into the chip's first scratch RAM byte and reads it back, to decide whether the chip is present.

Top module: `rtc_cal_seq`

## Requirements
- R1: After reset, cmd_ready=1, done=0, present=0, tx_req=0, and the read outputs are sec=0, min=0, hour=0, wday=0, mday=1, mon=0, year=100.
- R2: A command is taken only on a cycle with cmd_valid=1 and cmd_ready=1. cmd_op encodes 1=set, 2=read and 3=probe. A cmd_op of 0, or any cmd_valid while busy, has no effect: no transaction is issued and the running sequence is not changed.
- R3: A set starts with a write of 0x00 to control address 0x07 and ends with a write of 0x80 to the same address.
- R4: After unlocking, a set reads seconds (address 0x00) and writes back the value read, with bit 7 set.
- R5: A set then writes BCD bytes in this order: seconds to 0x00, minutes to 0x01, hours to 0x02, weekday to 0x05, day of month to 0x03, month to 0x04, year to 0x06. A BCD byte holds the tens digit in bits 7:4 and the units digit in bits 3:0.
- R6: The month byte is the 0-based input plus one. The year byte is the input year modulo 100.
- R7: After loading, a set reads seconds again and writes back the value read, with bit 7 cleared, before the final relock.
- R8: A read fetches addresses 0x00, 0x01, 0x02, 0x05, 0x03, 0x04 and 0x06 in that order and converts each byte from BCD. Bit 7 of the seconds byte (the halt flag) is ignored.
- R9: The read month output is the stored month minus one. A stored year below 70 is returned plus 100, and one of 70 or more is returned unchanged.
- R10: A probe writes 0x42 to address 0x20 and then reads 0x20. present becomes 1 if the byte read back equals 0x42, and 0 otherwise.
- R11: tx_req stays high, with tx_write, tx_addr and tx_wdata stable, until tx_ack. done pulses for exactly one cycle, on the cycle after the acknowledge of the last transaction, and cmd_ready returns to 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 1 set, 2 read, 3 probe |
| cmd_ready | output | 1 | Idle, command can be taken |
| in_sec | input | 8 | Binary seconds to set |
| in_min | input | 8 | Binary minutes to set |
| in_hour | input | 8 | Binary hours to set |
| in_wday | input | 8 | Binary weekday to set |
| in_mday | input | 8 | Binary day of month to set |
| in_mon | input | 8 | 0-based month to set |
| in_year | input | 8 | Years since 1900 to set |
| tx_req | output | 1 | Transaction request to serial master |
| tx_write | output | 1 | 1 write, 0 read |
| tx_addr | output | ADDR_W | Chip register address |
| tx_wdata | output | 8 | Write byte |
| tx_ack | input | 1 | Transaction complete |
| tx_rdata | input | 8 | Read byte, valid with tx_ack |
| done | output | 1 | One-cycle completion pulse |
| present | output | 1 | Probe result |
| out_sec | output | 8 | Binary seconds read |
| out_min | output | 8 | Binary minutes read |
| out_hour | output | 8 | Binary hours read |
| out_wday | output | 8 | Binary weekday read |
| out_mday | output | 8 | Binary day of month read |
| out_mon | output | 8 | 0-based month read |
| out_year | output | 8 | Years since 1900 read |

## Verification
The bench builds the block with its default parameters: a 6-bit address, probe marker 0x42 and a century pivot of 70. With these values the stored years 0x69 and 0x70 fall on either side of the pivot, so both branches of the year fix-up can be reached with ordinary stimulus. A scoreboard predicts every byte transaction of each set, read and probe, including the two read-modify-write values on the seconds register. The bench drives these sequences against a register model that stands in for the serial master, and can corrupt the scratch byte to force a failed probe.

// File: rtl/rtc_cal_seq.sv
module rtc_cal_seq #(
  parameter int ADDR_W = 6,
  parameter logic [7:0] PROBE_BYTE = 8'h42,
  parameter int PIVOT = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  output logic              cmd_ready,
  input  logic [7:0]        in_sec,
  input  logic [7:0]        in_min,
  input  logic [7:0]        in_hour,
  input  logic [7:0]        in_wday,
  input  logic [7:0]        in_mday,
  input  logic [7:0]        in_mon,
  input  logic [7:0]        in_year,
  output logic              tx_req,
  output logic              tx_write,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [7:0]        tx_wdata,
  input  logic              tx_ack,
  input  logic [7:0]        tx_rdata,
  output logic              done,
  output logic              present,
  output logic [7:0]        out_sec,
  output logic [7:0]        out_min,
  output logic [7:0]        out_hour,
  output logic [7:0]        out_wday,
  output logic [7:0]        out_mday,
  output logic [7:0]        out_mon,
  output logic [7:0]        out_year
);
  localparam int NF = 7;
  localparam int SET_LAST = 12;
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_RAM  = ADDR_W'(32);

  typedef enum logic [1:0] {OP_IDLE, OP_SET, OP_READ, OP_PROBE} op_t;

  op_t        op;
  logic [3:0] step;
  logic [7:0] rbuf;
  logic [7:0] ld  [NF];
  logic [7:0] raw [NF];
  logic [3:0] last;
  logic [2:0] fidx;

  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    logic [7:0] m;
    m = v % 8'd100;
    return {4'(m / 8'd10), 4'(m % 8'd10)};
  endfunction

  function automatic logic [7:0] from_bcd(input logic [7:0] b);
    return 8'(b[7:4] * 4'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] field_addr(input logic [2:0] i);
    case (i)
      3'd3:    return ADDR_W'(5);
      3'd4:    return ADDR_W'(3);
      3'd5:    return ADDR_W'(4);
      default: return ADDR_W'(i);
    endcase
  endfunction

  assign cmd_ready = (op == OP_IDLE);
  assign tx_req    = (op != OP_IDLE);
  assign last      = (op == OP_SET) ? 4'(SET_LAST) : (op == OP_READ) ? 4'(NF - 1) : 4'd1;
  assign fidx      = (op == OP_SET) ? 3'(step - 4'd3) : step[2:0];

  always_comb begin
    tx_write = 1'b1;
    tx_addr  = A_SEC;
    tx_wdata = 8'h00;
    case (op)
      OP_SET:
        case (step)
          4'd0:  tx_addr = A_CTRL;
          4'd1, 4'd10: tx_write = 1'b0;
          4'd2:  tx_wdata = rbuf | 8'h80;
          4'd11: tx_wdata = rbuf & 8'h7f;
          4'd12: begin tx_addr = A_CTRL; tx_wdata = 8'h80; end
          default: begin tx_addr = field_addr(fidx); tx_wdata = ld[fidx]; end
        endcase
      OP_READ: begin tx_write = 1'b0; tx_addr = field_addr(step[2:0]); end
      OP_PROBE: begin
        tx_addr  = A_RAM;
        tx_write = (step == 4'd0);
        tx_wdata = PROBE_BYTE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op      <= OP_IDLE;
      step    <= '0;
      rbuf    <= '0;
      done    <= 1'b0;
      present <= 1'b0;
      for (int i = 0; i < NF; i++) begin
        ld[i]  <= '0;
        raw[i] <= (i == 4 || i == 5) ? 8'h01 : 8'h00;
      end
    end else begin
      done <= 1'b0;
      if (op == OP_IDLE) begin
        if (cmd_valid && cmd_op != 2'd0) begin
          op   <= op_t'(cmd_op);
          step <= '0;
          ld[0] <= to_bcd(in_sec);
          ld[1] <= to_bcd(in_min);
          ld[2] <= to_bcd(in_hour);
          ld[3] <= to_bcd(in_wday);
          ld[4] <= to_bcd(in_mday);
          ld[5] <= to_bcd(in_mon + 8'd1);
          ld[6] <= to_bcd(in_year);
        end
      end else if (tx_ack) begin
        if (!tx_write) rbuf <= tx_rdata;
        if (op == OP_READ) raw[step[2:0]] <= tx_rdata;
        if (op == OP_PROBE && step == 4'd1) present <= (tx_rdata == PROBE_BYTE);
        if (step == last) begin
          op   <= OP_IDLE;
          done <= 1'b1;
        end else begin
          step <= step + 4'd1;
        end
      end
    end
  end

  logic [7:0] yr;
  assign yr       = from_bcd(raw[6]);
  assign out_sec  = from_bcd({1'b0, raw[0][6:0]});
  assign out_min  = from_bcd(raw[1]);
  assign out_hour = from_bcd(raw[2]);
  assign out_wday = from_bcd(raw[3]);
  assign out_mday = from_bcd(raw[4]);
  assign out_mon  = from_bcd(raw[5]) - 8'd1;
  assign out_year = (yr < 8'(PIVOT)) ? yr + 8'd100 : yr;

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ack |=> tx_req && $stable(tx_addr) && $stable(tx_write) && $stable(tx_wdata));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready && !tx_req);
  p_ctrl_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_write && tx_addr == A_CTRL |-> tx_wdata == 8'h00 || tx_wdata == 8'h80);
  p_busy_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ack |=> tx_req);
endmodule

// File: tb/tb_rtc_cal_seq.sv
module tb_rtc_cal_seq;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic cmd_valid = 0; logic [1:0] cmd_op = 0; logic cmd_ready;
  logic [7:0] in_sec = 0, in_min = 0, in_hour = 0, in_wday = 0, in_mday = 0, in_mon = 0, in_year = 0;
  logic tx_req, tx_write, tx_ack = 0; logic [5:0] tx_addr; logic [7:0] tx_wdata, tx_rdata = 0;
  logic done, present;
  logic [7:0] out_sec, out_min, out_hour, out_wday, out_mday, out_mon, out_year;

  rtc_cal_seq dut (.*);

  int errors = 0, checks = 0, ntx = 0;
  logic [7:0] mem [64];
  logic corrupt = 0;
  logic [14:0] expq [$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin errors++; $display("FAIL %s: actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [7:0] bcd(int v); return 8'(((v % 100) / 10) * 16 + v % 10); endfunction
  task automatic push(bit w, int a, int d); expq.push_back({w, 6'(a), 8'(w ? d : 0)}); endtask

  always @(negedge clk) begin
    if (tx_req && !tx_ack) begin
      ntx++;
      if (expq.size() == 0) chk("R2 unexpected transaction", {tx_write, tx_addr, tx_wdata}, 0);
      else chk("R3-R10 transaction", {tx_write, tx_addr, tx_write ? tx_wdata : 8'h00}, expq.pop_front());
      if (tx_write) mem[tx_addr] = (corrupt && tx_addr == 6'h20) ? tx_wdata ^ 8'h01 : tx_wdata;
      else tx_rdata = mem[tx_addr];
      tx_ack = 1;
    end else tx_ack = 0;
  end

  task automatic run(int op);
    int n;
    @(negedge clk); cmd_valid = 1; cmd_op = 2'(op);
    @(negedge clk); cmd_valid = 0; cmd_op = 0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) chk("watchdog", 1, 0);
    chk("R11 ready with done", cmd_ready, 1);
    @(negedge clk); chk("R11 done one cycle", done, 0);
    chk("R2 queue drained", expq.size(), 0);
  endtask

  task automatic set_time(int s, int mi, int h, int wd, int md, int mo, int y);
    logic [7:0] pre;
    pre = mem[0];
    in_sec = 8'(s); in_min = 8'(mi); in_hour = 8'(h); in_wday = 8'(wd);
    in_mday = 8'(md); in_mon = 8'(mo); in_year = 8'(y);
    push(1, 7, 0); push(0, 0, 0); push(1, 0, pre | 8'h80);            // R3 R4
    push(1, 0, bcd(s)); push(1, 1, bcd(mi)); push(1, 2, bcd(h));       // R5
    push(1, 5, bcd(wd)); push(1, 3, bcd(md)); push(1, 4, bcd(mo + 1)); // R6
    push(1, 6, bcd(y % 100)); push(0, 0, 0); push(1, 0, bcd(s));       // R7
    push(1, 7, 8'h80);
    run(1);
  endtask

  task automatic read_time();
    push(0, 0, 0); push(0, 1, 0); push(0, 2, 0); push(0, 5, 0);
    push(0, 3, 0); push(0, 4, 0); push(0, 6, 0);
    run(2);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    mem[0] = 8'h12;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", cmd_ready, 1); chk("R1 done", done, 0); chk("R1 present", present, 0);
    chk("R1 req", tx_req, 0); chk("R1 mday", out_mday, 1); chk("R1 mon", out_mon, 0);
    chk("R1 year", out_year, 100); chk("R1 sec", out_sec, 0);

    set_time(45, 7, 23, 3, 31, 11, 124);
    chk("R5 sec stored", mem[0], 8'h45); chk("R5 hour stored", mem[2], 8'h23);
    chk("R5 wday stored", mem[5], 8'h03); chk("R6 month stored", mem[4], 8'h12);
    chk("R6 year stored", mem[6], 8'h24); chk("R3 relocked", mem[7], 8'h80);

    read_time();
    chk("R8 sec", out_sec, 45); chk("R8 min", out_min, 7); chk("R8 hour", out_hour, 23);
    chk("R8 wday", out_wday, 3); chk("R8 mday", out_mday, 31);
    chk("R9 mon", out_mon, 11); chk("R9 year", out_year, 124);

    mem[0] = 8'hB0; mem[6] = 8'h69;
    read_time();
    chk("R8 halt bit ignored", out_sec, 30); chk("R9 year 69", out_year, 169);
    mem[6] = 8'h70; read_time(); chk("R9 year 70", out_year, 70);
    mem[6] = 8'h85; read_time(); chk("R9 year 85", out_year, 85);

    mem[0] = 8'h59;
    set_time(0, 0, 0, 0, 1, 0, 100);
    chk("R6 year 2000 stored", mem[6], 8'h00); chk("R6 jan stored", mem[4], 8'h01);

    push(1, 32, 8'h42); push(0, 32, 0); run(3);
    chk("R10 present", present, 1);
    corrupt = 1; push(1, 32, 8'h42); push(0, 32, 0); run(3); corrupt = 0;
    chk("R10 absent", present, 0);

    ntx = 0;
    @(negedge clk); cmd_valid = 1; cmd_op = 0;
    @(negedge clk); cmd_valid = 0;
    repeat (4) @(negedge clk);
    chk("R2 op zero no tx", ntx, 0); chk("R2 op zero ready", cmd_ready, 1);

    push(0, 0, 0); push(0, 1, 0); push(0, 2, 0); push(0, 5, 0);
    push(0, 3, 0); push(0, 4, 0); push(0, 6, 0);
    @(negedge clk); cmd_valid = 1; cmd_op = 2;
    @(negedge clk); cmd_op = 1;
    @(negedge clk); cmd_op = 3;
    @(negedge clk); cmd_valid = 0; cmd_op = 0;
    begin
      int n = 0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
      if (n >= 2000) chk("watchdog", 1, 0);
    end
    @(negedge clk);
    chk("R2 busy commands ignored", expq.size(), 0);
    chk("R2 read count", ntx, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule